// File: doc/BRIEF.md
# Multiplexed Shared Bus Resolver

This block stands in for an on-chip bus that several sources would otherwise share through tri-state buffers. Each of the `NDRV` sources presents a data word of `WIDTH` bits and a drive-enable bit. The block combines them into one bus word using only gates and multiplexing, so the bus is always at a defined level.

When exactly one source is enabled, its word appears on the bus. When two or more are enabled at once, every bus bit is forced low. When none is enabled, every bus bit is forced high. Two flags report these cases: `clash` for more than one source and `idle` for none.

The block has no clock and no storage. Its outputs follow its inputs within the same cycle, so it can sit inside any timing path that a real shared bus would have occupied.

Top module: `tsbus_emul`

## Requirements
- R1: When exactly one bit of `drv_en` is set, `bus_out` equals that source's word, which sits at bits [i*WIDTH +: WIDTH] of `drv_data` for source i.
- R2: When two or more bits of `drv_en` are set, every bit of `bus_out` is 0.
- R3: When no bit of `drv_en` is set, every bit of `bus_out` is 1.
- R4: `clash` is 1 exactly when two or more bits of `drv_en` are set.
- R5: `idle` is 1 exactly when `drv_en` is all zero.
- R6: The data words of sources whose enable is 0 have no effect on `bus_out`, `clash` or `idle`.
- R7: The outputs are combinational. A change on any input shows on the outputs without waiting for a clock edge.
- R8: `clash` and `idle` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| drv_data | input | NDRV*WIDTH | Packed source words; source i at [i*WIDTH +: WIDTH] |
| drv_en | input | NDRV | Drive enable, one bit per source |
| bus_out | output | WIDTH | Resolved bus word |
| clash | output | 1 | Two or more sources enabled |
| idle | output | 1 | No source enabled |

## Verification
The block holds no state, so any internal fault shows up as a wrong word or a wrong flag at the ports, with no delay, for the very enable pattern that exposes it. Some faults are easy to miss. If the chain that detects a second enable is broken, only multi-hot patterns return a merged word where all zeros are expected. If a gate in one lane of the AND-OR tree is broken, it shows only when that source is the single active one. Sweeping every enable pattern, with several data sets, exposes both kinds on the first pattern that involves the faulty path.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_SOLE  = 2'd1,
    BUS_CLASH = 2'd2
  } bus_state_e;

  // Pass a word through when its lane is enabled, otherwise yield zero.
  function automatic logic [63:0] gate_word(input logic [63:0] word, input logic en);
    return en ? word : 64'd0;
  endfunction

  // Decide the driven level from the enable classification.
  function automatic bus_state_e classify(input logic any_on, input logic two_on);
    if (two_on)      return BUS_CLASH;
    else if (any_on) return BUS_SOLE;
    else             return BUS_IDLE;
  endfunction

endpackage

// File: rtl/tsb_enable_classify.sv
module tsb_enable_classify #(
  parameter int NDRV = 4
) (
  input  logic [NDRV-1:0] en,
  output logic            any_on,
  output logic            two_on
);
  logic [NDRV:0] seen_one;
  logic [NDRV:0] seen_two;

  assign seen_one[0] = 1'b0;
  assign seen_two[0] = 1'b0;

  for (genvar i = 0; i < NDRV; i++) begin : g_chain
    assign seen_one[i+1] = seen_one[i] | en[i];
    assign seen_two[i+1] = seen_two[i] | (seen_one[i] & en[i]);
  end

  assign any_on = seen_one[NDRV];
  assign two_on = seen_two[NDRV];

  always_comb begin
    a_r4_two_means_multi: assert (two_on == ($countones(en) >= 2));
    a_r5_none_means_zero: assert (any_on == (en != '0));
  end
endmodule

// File: rtl/tsb_and_or_mux.sv
module tsb_and_or_mux #(
  parameter int NDRV  = 4,
  parameter int WIDTH = 8
) (
  input  logic [NDRV*WIDTH-1:0] data,
  input  logic [NDRV-1:0]       en,
  output logic [WIDTH-1:0]      merged
);
  import tsb_pkg::*;

  logic [WIDTH-1:0] acc [NDRV+1];
  logic [63:0]      lane [NDRV];

  assign acc[0] = '0;

  for (genvar i = 0; i < NDRV; i++) begin : g_lane
    assign lane[i]  = gate_word(64'(data[i*WIDTH +: WIDTH]), en[i]);
    assign acc[i+1] = acc[i] | lane[i][WIDTH-1:0];
  end

  assign merged = acc[NDRV];

  // R1: a lone enable passes exactly that source's word.
  always_comb begin
    for (int k = 0; k < NDRV; k++) begin
      if (en == (NDRV'(1) << k)) begin
        a_r1_sole_word: assert (merged == data[k*WIDTH +: WIDTH]);
      end
    end
  end
endmodule

// File: rtl/tsb_resolve.sv
module tsb_resolve #(
  parameter int WIDTH = 8
) (
  input  tsb_pkg::bus_state_e state,
  input  logic [WIDTH-1:0]    merged,
  output logic [WIDTH-1:0]    bus
);
  import tsb_pkg::*;

  always_comb begin
    unique case (state)
      BUS_CLASH: bus = '0;
      BUS_IDLE:  bus = '1;
      default:   bus = merged;
    endcase
  end
endmodule

// File: rtl/tsbus_emul.sv
module tsbus_emul #(
  parameter int NDRV  = 4,
  parameter int WIDTH = 8
) (
  input  logic [NDRV*WIDTH-1:0] drv_data,
  input  logic [NDRV-1:0]       drv_en,
  output logic [WIDTH-1:0]      bus_out,
  output logic                  clash,
  output logic                  idle
);
  import tsb_pkg::*;

  localparam int TOTAL_BITS = NDRV * WIDTH;

  logic                  any_on;
  logic                  two_on;
  logic [WIDTH-1:0]      merged;
  bus_state_e            state;

  if (NDRV < 2) begin : g_bad_ndrv
    initial $error("NDRV must be at least 2");
  end

  tsb_enable_classify #(.NDRV(NDRV)) u_cls (
    .en     (drv_en),
    .any_on (any_on),
    .two_on (two_on)
  );

  tsb_and_or_mux #(.NDRV(NDRV), .WIDTH(WIDTH)) u_mux (
    .data   (drv_data[TOTAL_BITS-1:0]),
    .en     (drv_en),
    .merged (merged)
  );

  assign state = classify(any_on, two_on);

  tsb_resolve #(.WIDTH(WIDTH)) u_res (
    .state  (state),
    .merged (merged),
    .bus    (bus_out)
  );

  assign clash = two_on;
  assign idle  = ~any_on;

  always_comb begin
    a_r8_flags_exclusive: assert (!(clash && idle));
    if ($countones(drv_en) >= 2) begin
      a_r2_clash_low: assert (bus_out == '0);
    end
    if (drv_en == '0) begin
      a_r3_idle_high: assert (bus_out == '1);
    end
  end
endmodule

// File: tb/sim_tsbus_emul.sv
module sim_tsbus_emul;
  localparam int NDRV  = 4;
  localparam int WIDTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NDRV*WIDTH-1:0] drv_data;
  logic [NDRV-1:0]       drv_en;
  logic [WIDTH-1:0]      bus_out;
  logic                  clash;
  logic                  idle;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tsbus_emul #(.NDRV(NDRV), .WIDTH(WIDTH)) u0 (
    .drv_data (drv_data),
    .drv_en   (drv_en),
    .bus_out  (bus_out),
    .clash    (clash),
    .idle     (idle)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Bench's own reference: count enables, pick the word by index.
  task automatic check_all(input string tag);
    int ones = 0;
    int who = 0;
    logic [WIDTH-1:0] exp_bus;
    for (int i = 0; i < NDRV; i++) if (drv_en[i]) begin ones++; who = i; end
    if (ones == 0)      exp_bus = {WIDTH{1'b1}};
    else if (ones == 1) exp_bus = drv_data[who*WIDTH +: WIDTH];
    else                exp_bus = '0;
    if (ones == 1)      chk({tag, " R1"}, 32'(bus_out), 32'(exp_bus));
    else if (ones == 0) chk({tag, " R3"}, 32'(bus_out), 32'(exp_bus));
    else                chk({tag, " R2"}, 32'(bus_out), 32'(exp_bus));
    chk({tag, " R4"}, 32'(clash), 32'(ones >= 2));
    chk({tag, " R5"}, 32'(idle), 32'(ones == 0));
    chk({tag, " R8"}, 32'(clash & idle), 32'd0);
  endtask

  task automatic t_after_reset();
    @(negedge clk);
    drv_en = '0;
    drv_data = 32'hA5C3_0F96;
    #1;
    check_all("reset");
  endtask

  task automatic t_sweep(input logic [31:0] seed);
    for (int p = 0; p < (1 << NDRV); p++) begin
      @(negedge clk);
      for (int i = 0; i < NDRV; i++)
        drv_data[i*WIDTH +: WIDTH] = WIDTH'(seed + 32'(p*37) + 32'(i*91));
      drv_en = NDRV'(p);
      #1;
      check_all("sweep");
    end
  endtask

  // R6: with source 2 alone enabled, scrambling the others leaves the bus alone.
  task automatic t_ignore_others();
    logic [WIDTH-1:0] held;
    @(negedge clk);
    drv_data = 32'h1122_3344;
    drv_en = 4'b0100;
    #1;
    held = bus_out;
    chk("R6 base", 32'(held), 32'h22);
    for (int k = 0; k < 4; k++) begin
      drv_data[0 +: 16] = 16'(k * 16'h5A5B + 16'h0F0F);
      drv_data[24 +: 8] = 8'(k * 8'h3D + 8'hC1);
      #1;
      chk("R6 bus", 32'(bus_out), 32'(held));
      chk("R6 flags", {30'd0, clash, idle}, 32'd0);
    end
    drv_en = '0;
    drv_data = '0;
    #1;
    chk("R6 idle bus", 32'(bus_out), 32'hFF);
  endtask

  // R7: change inputs mid-cycle, far from any edge, outputs follow at once.
  task automatic t_comb();
    @(posedge clk);
    #1;
    drv_data = 32'h00_00_7E_00;
    drv_en = 4'b0010;
    #0.5;
    chk("R7 follow", 32'(bus_out), 32'h7E);
    drv_en = 4'b0011;
    #0.5;
    chk("R7 clash", 32'(bus_out), 32'h00);
    chk("R7 flag", 32'(clash), 32'd1);
  endtask

  initial begin
    drv_en = '0;
    drv_data = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_after_reset();
    t_sweep(32'h0000_0013);
    t_sweep(32'h0000_00F0);
    t_sweep(32'h0000_0081);
    t_ignore_others();
    t_comb();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule